// File: doc/BRIEF.md
# Dictionary Range-Scan Extraction Sequencer

This block finds every dictionary key that occurs at each position of a text, for texts where each position may hold several candidate characters. A host first writes the keys, sorted so that keys with a common first character are contiguous. Each key occupies one address that is shared by KEY_LEN per-position character memories. The host also writes a first-character table that gives a top address and an entry count for each character. A key shorter than KEY_LEN is padded with the wildcard code 0, and a padded slot matches anything.

After a start pulse the block loads KEY_LEN text columns into a window of shift registers. A column is one character per candidate level. For each window state the block visits the levels in turn, starting at level 0, which is the highest-ranked candidate. For each level it looks up the range of that level's position-1 character and steps one address across the range, taking three cycles per address. A key counts as a hit when every key position equals the wildcard or equals some level's character at that window position. After the last level the window shifts by one column. The run stops when the end code appears at level 0 of position 1.

Top module: `dict_scan_seq`

## Requirements
- R1: While reset is held, and in the cycle after it is released, `hit_valid`, `done` and `text_ready` are all 0.
- R2: A start pulse in idle begins a load. During the load exactly KEY_LEN columns enter the window, one per cycle when `text_valid` is high. `text_ready` is high in each load cycle until the end column has been accepted.
- R3: For each level, the index table is looked up with that level's position-1 character, and the lookup takes one cycle. A count of 0, or a character code of 2^IDX_W or more, moves straight to the next level, or to the shift after the last level, with no compare cycles.
- R4: A hit is reported at an address only when each of the KEY_LEN key characters is either 0 (wildcard) or equal to the character of at least one level at the same window position. Otherwise the address only advances.
- R5: Each address in a range takes exactly three cycles. A hit appears as a one-cycle `hit_valid` pulse in the third cycle, carrying the address in `hit_addr`.
- R6: Levels are visited in the order 0, 1, ..., LEVELS-1 before each single shift, and `hit_level` gives the level whose range produced the hit.
- R7: `hit_pos` gives the number of window shifts since the load finished, which is the text index at window position 1, counting from 0.
- R8: The end code (all ones) in level 0 of position 1 raises `done` in the cycle after the check, with no lookup. After the end column is accepted, `text_ready` stays 0 and shifts insert end codes into every level.
- R9: `done` stays high until the next start pulse. The start pulse clears `done` in the following cycle and begins a new load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a run; takes effect only in idle |
| dict_we | input | 1 | Write one key into the dictionary |
| dict_waddr | input | DICT_AW | Key address |
| dict_wkey | input | KEY_LEN*CHAR_W | Key characters, position 1 in the low bits |
| idx_we | input | 1 | Write one index entry |
| idx_waddr | input | IDX_W | First character of the entry |
| idx_wtop | input | DICT_AW | First address of the range |
| idx_wcnt | input | DICT_AW+1 | Number of keys in the range |
| text_valid | input | 1 | A text column is offered |
| text_ready | output | 1 | The block takes the offered column this cycle |
| text_col | input | LEVELS*CHAR_W | One character per level, level 0 in the low bits |
| hit_valid | output | 1 | One-cycle hit pulse |
| hit_addr | output | DICT_AW | Address of the matching key |
| hit_pos | output | POS_W | Text index at window position 1 |
| hit_level | output | max(1,clog2(LEVELS)) | Level that supplied the range |
| done | output | 1 | End code reached position 1 |

## Verification
The assertions assume the following about the inputs. The host writes the dictionary and the index only while the block is idle. Every index range lies inside the dictionary. No key holds the end code. Start arrives only when no run is in progress. The bench writes all tables before the first start. It pulses start only after the reference model reports that the previous run has finished. It uses character codes below 27 in keys and text, and every text ends with a column made only of end codes.

// File: rtl/dscan_pkg.sv
// Shared types for the dictionary range-scan sequencer.
// Assumes: nothing beyond IEEE 1800-2017 enums.
package dscan_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FILL,
        ST_CHECK,
        ST_LOOKUP,
        ST_P0,
        ST_P1,
        ST_P2,
        ST_SHIFT
    } dscan_state_t;

endpackage

// File: rtl/dscan_dict.sv
// Key store: KEY_LEN character memories that share one address.
// Reads are registered, so a key is available one cycle after its address.
// Assumes: writes happen only while the sequencer is idle.
module dscan_dict #(
    parameter int KEY_LEN = 8,
    parameter int CHAR_W  = 16,
    parameter int DICT_AW = 6
) (
    input  logic                        clk,
    input  logic                        we,
    input  logic [DICT_AW-1:0]          waddr,
    input  logic [KEY_LEN*CHAR_W-1:0]   wkey,
    input  logic [DICT_AW-1:0]          raddr,
    output logic [KEY_LEN*CHAR_W-1:0]   rkey
);
    localparam int DEPTH = 1 << DICT_AW;

    for (genvar j = 0; j < KEY_LEN; j++) begin : g_pos
        logic [CHAR_W-1:0] mem [DEPTH];

        // Write one position of a key and read the same position at raddr.
        always_ff @(posedge clk) begin
            if (we) mem[waddr] <= wkey[j*CHAR_W +: CHAR_W];
            rkey[j*CHAR_W +: CHAR_W] <= mem[raddr];
        end
    end
endmodule

// File: rtl/dscan_index.sv
// First-character table: for each character, the first address and the number
// of keys that start with it. Codes at or above 2^IDX_W report an empty range.
// Assumes: writes happen only while the sequencer is idle.
module dscan_index #(
    parameter int CHAR_W  = 16,
    parameter int IDX_W   = 8,
    parameter int DICT_AW = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [IDX_W-1:0]     waddr,
    input  logic [DICT_AW-1:0]   wtop,
    input  logic [DICT_AW:0]     wcnt,
    input  logic [CHAR_W-1:0]    look_char,
    output logic [DICT_AW-1:0]   look_top,
    output logic [DICT_AW:0]     look_cnt
);
    localparam int ENTRIES = 1 << IDX_W;

    logic [DICT_AW-1:0] top_mem [ENTRIES];
    logic [DICT_AW:0]   cnt_mem [ENTRIES];
    logic               in_table;

    // Store entries; reset empties every range.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int e = 0; e < ENTRIES; e++) begin
                top_mem[e] <= '0;
                cnt_mem[e] <= '0;
            end
        end else if (we) begin
            top_mem[waddr] <= wtop;
            cnt_mem[waddr] <= wcnt;
        end
    end

    if (CHAR_W > IDX_W) begin : g_range
        // Characters beyond the table are treated as having no keys.
        assign in_table = (look_char[CHAR_W-1:IDX_W] == '0);
    end else begin : g_full
        assign in_table = 1'b1;
    end

    // Read the range of the looked-up character.
    always_comb begin
        look_top = top_mem[look_char[IDX_W-1:0]];
        look_cnt = in_table ? cnt_mem[look_char[IDX_W-1:0]] : '0;
    end
endmodule

// File: rtl/dscan_window.sv
// Text window: LEVELS rows of KEY_LEN character registers that shift together
// toward position 1. It also holds the comparator bank: a key position matches
// when it is the wildcard or equals any level's character at that position.
// Assumes: in_col carries level 0 in its low bits.
module dscan_window #(
    parameter int                KEY_LEN   = 8,
    parameter int                LEVELS    = 3,
    parameter int                CHAR_W    = 16,
    parameter int                LVL_W     = 2,
    parameter logic [CHAR_W-1:0] WILD_CHAR = '0,
    parameter logic [CHAR_W-1:0] END_CHAR  = '1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        shift_en,
    input  logic [LEVELS*CHAR_W-1:0]    in_col,
    input  logic [LVL_W-1:0]            sel_lvl,
    input  logic [KEY_LEN*CHAR_W-1:0]   key,
    output logic [CHAR_W-1:0]           head_sel,
    output logic [CHAR_W-1:0]           head_top,
    output logic                        all_match
);
    logic [CHAR_W-1:0] win [LEVELS][KEY_LEN];
    logic [KEY_LEN-1:0] pos_hit;

    for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
        for (genvar j = 0; j < KEY_LEN; j++) begin : g_pos
            // Shift one column toward position 1; new data enters at the far end.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    win[l][j] <= END_CHAR;
                end else if (shift_en) begin
                    if (j == KEY_LEN - 1) win[l][j] <= in_col[l*CHAR_W +: CHAR_W];
                    else                  win[l][j] <= win[l][(j == KEY_LEN - 1) ? j : j + 1];
                end
            end
        end
    end

    for (genvar j = 0; j < KEY_LEN; j++) begin : g_cmp
        // Match one key position against every level at that position.
        always_comb begin
            pos_hit[j] = (key[j*CHAR_W +: CHAR_W] == WILD_CHAR);
            for (int l = 0; l < LEVELS; l++) begin
                if (win[l][j] == key[j*CHAR_W +: CHAR_W]) pos_hit[j] = 1'b1;
            end
        end
    end

    // Select the position-1 character of the current level.
    always_comb begin
        head_sel = win[0][0];
        for (int l = 0; l < LEVELS; l++) begin
            if (sel_lvl == LVL_W'(l)) head_sel = win[l][0];
        end
    end

    assign head_top  = win[0][0];
    assign all_match = &pos_hit;
endmodule

// File: rtl/dict_scan_seq.sv
// Sequencer top: loads the window, then for each window state walks every
// candidate level, scans that level's index range at three cycles per address,
// pulses hits, and shifts once. Stops when the end code reaches position 1.
// Assumes: tables are written in idle and each range fits the dictionary.
module dict_scan_seq
    import dscan_pkg::*;
#(
    parameter int                KEY_LEN   = 8,
    parameter int                LEVELS    = 3,
    parameter int                CHAR_W    = 16,
    parameter int                DICT_AW   = 6,
    parameter int                IDX_W     = 8,
    parameter int                POS_W     = 16,
    parameter logic [CHAR_W-1:0] WILD_CHAR = '0,
    parameter logic [CHAR_W-1:0] END_CHAR  = '1,
    localparam int               LVL_W     = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start,
    input  logic                        dict_we,
    input  logic [DICT_AW-1:0]          dict_waddr,
    input  logic [KEY_LEN*CHAR_W-1:0]   dict_wkey,
    input  logic                        idx_we,
    input  logic [IDX_W-1:0]            idx_waddr,
    input  logic [DICT_AW-1:0]          idx_wtop,
    input  logic [DICT_AW:0]            idx_wcnt,
    input  logic                        text_valid,
    output logic                        text_ready,
    input  logic [LEVELS*CHAR_W-1:0]    text_col,
    output logic                        hit_valid,
    output logic [DICT_AW-1:0]          hit_addr,
    output logic [POS_W-1:0]            hit_pos,
    output logic [LVL_W-1:0]            hit_level,
    output logic                        done
);
    localparam int FILL_W = $clog2(KEY_LEN + 1);
    localparam logic [LVL_W-1:0] LAST_LVL = LVL_W'(LEVELS - 1);

    dscan_state_t         state;
    logic [LVL_W-1:0]     lvl;
    logic [DICT_AW-1:0]   cur_addr;
    logic [DICT_AW:0]     left;
    logic [POS_W-1:0]     pos;
    logic [FILL_W-1:0]    fill_cnt;
    logic                 end_seen;
    logic                 done_r;
    logic                 match_r;

    logic [KEY_LEN*CHAR_W-1:0] rkey;
    logic [CHAR_W-1:0]         head_sel, head_top;
    logic                      all_match;
    logic [DICT_AW-1:0]        look_top;
    logic [DICT_AW:0]          look_cnt;
    logic                      accept, shift_en;
    logic [LEVELS*CHAR_W-1:0]  shift_col;

    dscan_dict #(.KEY_LEN(KEY_LEN), .CHAR_W(CHAR_W), .DICT_AW(DICT_AW)) u_dict (
        .clk   (clk),
        .we    (dict_we),
        .waddr (dict_waddr),
        .wkey  (dict_wkey),
        .raddr (cur_addr),
        .rkey  (rkey)
    );

    dscan_index #(.CHAR_W(CHAR_W), .IDX_W(IDX_W), .DICT_AW(DICT_AW)) u_index (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (idx_we),
        .waddr     (idx_waddr),
        .wtop      (idx_wtop),
        .wcnt      (idx_wcnt),
        .look_char (head_sel),
        .look_top  (look_top),
        .look_cnt  (look_cnt)
    );

    dscan_window #(
        .KEY_LEN(KEY_LEN), .LEVELS(LEVELS), .CHAR_W(CHAR_W), .LVL_W(LVL_W),
        .WILD_CHAR(WILD_CHAR), .END_CHAR(END_CHAR)
    ) u_window (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift_en  (shift_en),
        .in_col    (shift_col),
        .sel_lvl   (lvl),
        .key       (rkey),
        .head_sel  (head_sel),
        .head_top  (head_top),
        .all_match (all_match)
    );

    // Column handshake and window shift control.
    always_comb begin
        text_ready = ((state == ST_FILL) || (state == ST_SHIFT)) && !end_seen;
        accept     = text_valid && text_ready;
        shift_en   = ((state == ST_FILL) || (state == ST_SHIFT)) && (accept || end_seen);
        shift_col  = end_seen ? {LEVELS{END_CHAR}} : text_col;
    end

    // Main sequence: load, check, per-level lookup, three-phase compare, shift.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            lvl      <= '0;
            cur_addr <= '0;
            left     <= '0;
            pos      <= '0;
            fill_cnt <= '0;
            end_seen <= 1'b0;
            done_r   <= 1'b0;
            match_r  <= 1'b0;
        end else begin
            if (accept && (text_col[CHAR_W-1:0] == END_CHAR)) end_seen <= 1'b1;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        state    <= ST_FILL;
                        fill_cnt <= '0;
                        pos      <= '0;
                        end_seen <= 1'b0;
                        done_r   <= 1'b0;
                    end
                end
                ST_FILL: begin
                    if (shift_en) begin
                        fill_cnt <= fill_cnt + 1'b1;
                        if (fill_cnt == FILL_W'(KEY_LEN - 1)) state <= ST_CHECK;
                    end
                end
                ST_CHECK: begin
                    if (head_top == END_CHAR) begin
                        state  <= ST_IDLE;
                        done_r <= 1'b1;
                    end else begin
                        lvl   <= '0;
                        state <= ST_LOOKUP;
                    end
                end
                ST_LOOKUP: begin
                    cur_addr <= look_top;
                    left     <= look_cnt;
                    if (look_cnt != '0)       state <= ST_P0;
                    else if (lvl == LAST_LVL) state <= ST_SHIFT;
                    else                      lvl   <= lvl + 1'b1;
                end
                ST_P0: state <= ST_P1;
                ST_P1: begin
                    match_r <= all_match;
                    state   <= ST_P2;
                end
                ST_P2: begin
                    cur_addr <= cur_addr + 1'b1;
                    left     <= left - 1'b1;
                    if (left != (DICT_AW+1)'(1)) begin
                        state <= ST_P0;
                    end else if (lvl == LAST_LVL) begin
                        state <= ST_SHIFT;
                    end else begin
                        lvl   <= lvl + 1'b1;
                        state <= ST_LOOKUP;
                    end
                end
                ST_SHIFT: begin
                    if (shift_en) begin
                        pos   <= pos + 1'b1;
                        state <= ST_CHECK;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Result outputs.
    assign hit_valid = (state == ST_P2) && match_r;
    assign hit_addr  = cur_addr;
    assign hit_pos   = pos;
    assign hit_level = lvl;
    assign done      = done_r;
endmodule

// File: rtl/dscan_chk.sv
// Protocol checker for dict_scan_seq, attached by bind below.
// Assumes: start is only pulsed while no run is in progress.
module dscan_chk #(
    parameter int LEVELS = 3,
    parameter int LVL_W  = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             text_ready,
    input logic             hit_valid,
    input logic [LVL_W-1:0] hit_level,
    input logic             done
);
    // R5: a hit is a single pulse and addresses are at least three cycles apart
    a_r5_hit_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        hit_valid |=> !hit_valid ##1 !hit_valid);

    // R6: the reported level is a real level
    a_r6_level_range: assert property (@(posedge clk) disable iff (!rst_n)
        hit_valid |-> (int'(hit_level) < LEVELS));

    // R8: a finished run neither reports hits nor takes text
    a_r8_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!hit_valid && !text_ready));

    // R9: done holds until a start pulse
    a_r9_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

    // R9: a start pulse clears done
    a_r9_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (done && start) |=> !done);
endmodule

bind dict_scan_seq dscan_chk #(.LEVELS(LEVELS), .LVL_W(LVL_W)) u_dscan_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .text_ready (text_ready),
    .hit_valid  (hit_valid),
    .hit_level  (hit_level),
    .done       (done)
);

// File: tb/dict_scan_seq_test.sv
// Bench for dict_scan_seq: a behavioural timeline model predicts every cycle,
// and the outputs are compared at each falling edge.
module dict_scan_seq_test;
    localparam int KL = 8;
    localparam int LV = 3;
    localparam int CW = 16;
    localparam int AW = 6;
    localparam int IW = 8;
    localparam int PW = 16;
    localparam int LW = 2;
    localparam logic [CW-1:0] ENDC = 16'hFFFF;
    localparam logic [CW-1:0] FILL_CODE = 16'd26;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic dict_we = 1'b0;
    logic [AW-1:0] dict_waddr = '0;
    logic [KL*CW-1:0] dict_wkey = '0;
    logic idx_we = 1'b0;
    logic [IW-1:0] idx_waddr = '0;
    logic [AW-1:0] idx_wtop = '0;
    logic [AW:0] idx_wcnt = '0;
    logic text_valid = 1'b0;
    logic text_ready;
    logic [LV*CW-1:0] text_col = '0;
    logic hit_valid;
    logic [AW-1:0] hit_addr;
    logic [PW-1:0] hit_pos;
    logic [LW-1:0] hit_level;
    logic done;

    always #10 clk = ~clk;

    dict_scan_seq #(.KEY_LEN(KL), .LEVELS(LV), .CHAR_W(CW), .DICT_AW(AW),
                    .IDX_W(IW), .POS_W(PW)) uut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .dict_we(dict_we), .dict_waddr(dict_waddr), .dict_wkey(dict_wkey),
        .idx_we(idx_we), .idx_waddr(idx_waddr), .idx_wtop(idx_wtop), .idx_wcnt(idx_wcnt),
        .text_valid(text_valid), .text_ready(text_ready), .text_col(text_col),
        .hit_valid(hit_valid), .hit_addr(hit_addr), .hit_pos(hit_pos),
        .hit_level(hit_level), .done(done)
    );

    int n_cmp = 0;
    int n_bad = 0;

    // Intended table contents.
    logic [CW-1:0] dkey [64][KL];
    int            itop [256];
    int            icnt [256];
    // Current text.
    logic [CW-1:0] col [32][LV];
    int            ncols = 0;
    int            feed_idx = 0;
    int            pending = 0;

    // Expected values.
    logic exp_hit = 1'b0, exp_done = 1'b0, exp_ready = 1'b0;
    int   exp_addr = 0, exp_pos = 0, exp_lvl = 0;
    logic model_busy = 1'b0;
    int   model_hits = 0, dut_hits = 0;

    function automatic logic [CW-1:0] code(byte c);
        return CW'(c - 8'd96);
    endfunction

    function automatic logic [CW-1:0] chr(int i, int l);
        if (i < ncols && i < 32) return col[i][l];
        return ENDC;
    endfunction

    function automatic logic key_hits(int a, int p);
        for (int j = 0; j < KL; j++) begin
            logic ok;
            if (dkey[a][j] == 16'd0) continue;
            ok = 1'b0;
            for (int l = 0; l < LV; l++) if (chr(p + j, l) == dkey[a][j]) ok = 1'b1;
            if (!ok) return 1'b0;
        end
        return 1'b1;
    endfunction

    task automatic check(string tag, string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic put_key(int a, string s);
        @(negedge clk);
        dict_we = 1'b1; dict_waddr = AW'(a); dict_wkey = '0;
        for (int j = 0; j < KL; j++) dkey[a][j] = 16'd0;
        for (int j = 0; j < s.len(); j++) begin
            dict_wkey[j*CW +: CW] = code(s[j]);
            dkey[a][j] = code(s[j]);
        end
        @(negedge clk); dict_we = 1'b0;
    endtask

    task automatic put_index(byte c, int top, int cnt);
        @(negedge clk);
        idx_we = 1'b1; idx_waddr = IW'(code(c)); idx_wtop = AW'(top); idx_wcnt = (AW+1)'(cnt);
        itop[code(c)] = top; icnt[code(c)] = cnt;
        @(negedge clk); idx_we = 1'b0;
    endtask

    task automatic set_text(string s0, string s1, string s2);
        ncols = s0.len() + 1;
        for (int i = 0; i < ncols - 1; i++) begin
            col[i][0] = code(s0[i]);
            col[i][1] = (i < s1.len()) ? code(s1[i]) : FILL_CODE;
            col[i][2] = (i < s2.len()) ? code(s2[i]) : FILL_CODE;
        end
        for (int l = 0; l < LV; l++) col[ncols-1][l] = ENDC;
        feed_idx = 0; pending = 0;
    endtask

    // Text source: advance after each accepted column, offer the next one.
    always @(negedge clk) begin
        feed_idx = feed_idx + pending;
        text_valid = (feed_idx < ncols);
        for (int l = 0; l < LV; l++) text_col[l*CW +: CW] = chr(feed_idx, l);
        pending = (text_valid && text_ready) ? 1 : 0;
    end

    // Reference timeline of one run, advanced edge by edge.
    initial begin
        forever begin
            @(posedge clk);
            if (rst_n && start) begin
                model_busy = 1'b1;
                exp_done = 1'b0;
                for (int k = 0; k < KL; k++) begin
                    exp_ready = (k <= ncols - 1);
                    @(posedge clk);
                end
                exp_ready = 1'b0;
                for (int p = 0; ; p++) begin
                    @(posedge clk);
                    if (chr(p, 0) == ENDC) begin
                        exp_done = 1'b1;
                        break;
                    end
                    for (int l = 0; l < LV; l++) begin
                        int c, top, cnt;
                        c = int'(chr(p, l));
                        top = (c < 256) ? itop[c] : 0;
                        cnt = (c < 256) ? icnt[c] : 0;
                        @(posedge clk);
                        for (int i = 0; i < cnt; i++) begin
                            @(posedge clk);
                            @(posedge clk);
                            exp_hit = key_hits(top + i, p);
                            exp_addr = top + i; exp_pos = p; exp_lvl = l;
                            if (exp_hit) model_hits++;
                            @(posedge clk);
                            exp_hit = 1'b0;
                        end
                    end
                    exp_ready = (p + KL <= ncols - 1);
                    @(posedge clk);
                    exp_ready = 1'b0;
                end
                model_busy = 1'b0;
            end
        end
    end

    // Per-cycle comparison against the model.
    always @(negedge clk) begin
        if (rst_n) begin
            if (hit_valid) dut_hits++;
            check("R5", "hit_valid timing", int'(hit_valid), int'(exp_hit));
            check("R8", "done", int'(done), int'(exp_done));
            check("R2", "text_ready", int'(text_ready), int'(exp_ready));
            if (exp_hit && hit_valid) begin
                check("R3", "hit_addr", int'(hit_addr), exp_addr);
                check("R7", "hit_pos", int'(hit_pos), exp_pos);
                check("R6", "hit_level", int'(hit_level), exp_lvl);
            end
        end
    end

    task automatic run_text(string name);
        model_hits = 0; dut_hits = 0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        while (model_busy) @(negedge clk);
        repeat (4) @(negedge clk);
        // R4: total hits for this text agree with the match rule
        check("R4", {name, " hit count"}, dut_hits, model_hits);
        // R9: done still held after idle cycles
        check("R9", {name, " done held"}, int'(done), 1);
    endtask

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        for (int e = 0; e < 256; e++) begin itop[e] = 0; icnt[e] = 0; end
        repeat (3) @(negedge clk);
        // R1: outputs quiet during reset
        check("R1", "hit_valid in reset", int'(hit_valid), 0);
        check("R1", "done in reset", int'(done), 0);
        check("R1", "text_ready in reset", int'(text_ready), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "done after reset", int'(done), 0);
        check("R1", "text_ready after reset", int'(text_ready), 0);

        put_key(0, "ab");  put_key(1, "abc"); put_key(2, "abd");
        put_key(3, "abcdabcd");
        put_key(4, "b");   put_key(5, "ba");  put_key(6, "c");
        put_key(7, "dab"); put_key(8, "dcb");
        put_index("a", 0, 4); put_index("b", 4, 2);
        put_index("c", 6, 1); put_index("d", 7, 2);

        // Single stream, full-length key and wildcard-padded keys; filler levels skip (R3).
        set_text("abcdabcdab", "", "");
        run_text("single");
        // Several levels combine per position; R6 order and R3 lookups of each level.
        set_text("dab", "cc", "aaa");
        run_text("multi");
        // Empty text: end code at once (R8), restart from done (R9).
        set_text("", "", "");
        run_text("empty");
        check("R8", "no hits on empty text", dut_hits, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule